// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor that reads and writes single bytes and a slower memory that only moves whole 16-byte lines. It keeps 256 lines. Each line holds a stored tag, a valid flag, a modified (dirty) flag and sixteen data bytes. A processor access whose line is resident and tagged for its address completes in the cycle it is presented. Any other access is held off while the controller brings the line in. If the line being replaced holds modified data, that data is first copied back to memory.

The processor raises `cpu_valid` and keeps the address, direction and write byte steady until `cpu_ready` is seen high at a clock edge. Only one request is in flight at a time. On the memory side, `mem_req` stays high with a steady address until the memory answers with a one-cycle `mem_ack`. A fill takes its line from `mem_rdata` on that edge, and a write-back presents its line on `mem_wdata`.

Top module: `cwb_cache`

## Requirements
- R1: After reset every line is invalid and modified-clear, `cpu_ready` and `mem_req` are low, and the first access to any address is served by a fill with no write-back.
- R2: The byte address is split as tag = bits 23:12, line index = bits 11:4 and byte offset = bits 3:0. Lines with different indices never displace one another.
- R3: An access whose indexed line is valid with a matching stored tag completes with `cpu_ready` high in the same cycle it is presented, and issues no memory request.
- R4: A read that completes returns on `cpu_rdata` the most recent byte written to that address, or the memory's byte if none was written.
- R5: A write that completes stores the byte at its offset and sets the line's modified flag without testing it, so a later replacement of that line copies it back.
- R6: When the indexed line is invalid, the controller goes straight to a fill. It raises `mem_req` with `mem_we` low and `mem_addr` = request bits 23:4 followed by four zero bits.
- R7: When the indexed line is valid, its tag differs and its modified flag is clear, the line is filled with no write-back.
- R8: When the indexed line is valid, its tag differs and it is modified, a write-back comes first. It has `mem_we` high, `mem_addr` = {stored tag, index, 4'b0000} and the full old line on `mem_wdata`, and only then does a fill follow.
- R9: A fill leaves the line valid and clean, after which the pending read or write is performed. A line that was only read after its fill is replaced later without a write-back.
- R10: `cpu_ready` stays low for the whole miss sequence. Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`, and only one memory transaction is open at a time.
- R11: On both memory data buses, byte k of a line (offset k) occupies bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory transaction open |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 24 | Line-aligned memory address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Line returned for a fill |
| mem_ack | input | 1 | Memory finishes the open transaction at this edge |

## Verification
A hit is due in the cycle the request is driven, so the bench looks for `cpu_ready` and the read byte one nanosecond after the falling edge on which it drove the request. On a miss, `mem_req` is due in the next cycle. After the write-back acknowledge (if there is one), the fill request is due one cycle later. After the fill acknowledge, `cpu_ready` is due one cycle later. The bench serves memory with a random delay of zero to three cycles. It samples each transaction's address and data at the falling edge on which it raises `mem_ack`, and counts the write-backs and fills per access against a reference line table. Any access that completes before its predicted transactions, or issues extra ones, is therefore reported.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic [1:0] {
      ST_LOOK = 2'd0,
      ST_WRBK = 2'd1,
      ST_FILL = 2'd2
   } cwb_state_e;
endpackage

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
   parameter int TAG_W = 12,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_en,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output logic             rd_dirty
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_q [LINES];
   logic [LINES-1:0] vld_q;
   logic [LINES-1:0] dty_q;

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx] <= fill_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         dty_q <= '0;
      end else if (fill_en) begin
         vld_q[idx] <= 1'b1;
         dty_q[idx] <= 1'b0;
      end else if (mark_en) begin
         dty_q[idx] <= 1'b1;
      end
   end

   assign rd_tag   = tag_q[idx];
   assign rd_valid = vld_q[idx];
   assign rd_dirty = dty_q[idx];

   // R9: a fill leaves its line valid and clean
   p_fill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vld_q[$past(idx)] && !dty_q[$past(idx)]));

   // R5: a completed write leaves its line marked modified
   p_mark_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_en && !fill_en) |=> dty_q[$past(idx)]);
endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store #(
   parameter int IDX_W = 8,
   parameter int OFF_W = 4
) (
   input  logic                         clk,
   input  logic [IDX_W-1:0]             idx,
   input  logic [OFF_W-1:0]             off,
   input  logic                         line_we,
   input  logic [(8<<OFF_W)-1:0]        line_wdata,
   input  logic                         byte_we,
   input  logic [7:0]                   byte_wdata,
   output logic [(8<<OFF_W)-1:0]        line_rdata
);
   localparam int LINES = 1 << IDX_W;
   localparam int LANES = 1 << OFF_W;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] lane_q [LINES];
      always_ff @(posedge clk) begin
         if (line_we)
            lane_q[idx] <= line_wdata[8*k +: 8];
         else if (byte_we && (off == OFF_W'(k)))
            lane_q[idx] <= byte_wdata;
      end
      assign line_rdata[8*k +: 8] = lane_q[idx];
   end
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
   import cwb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_valid,
   input  logic cpu_we,
   input  logic line_valid,
   input  logic tag_eq,
   input  logic line_dirty,
   input  logic mem_ack,
   output logic cpu_ready,
   output logic byte_we,
   output logic mark_en,
   output logic fill_en,
   output logic mem_req,
   output logic mem_we
);
   cwb_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOOK;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      byte_we   = 1'b0;
      mark_en   = 1'b0;
      fill_en   = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      unique case (state_q)
         ST_LOOK: begin
            if (cpu_valid) begin
               if (!line_valid)      state_d = ST_FILL;
               else if (tag_eq) begin
                  cpu_ready = 1'b1;
                  byte_we   = cpu_we;
                  mark_en   = cpu_we;
               end
               else if (line_dirty)  state_d = ST_WRBK;
               else                  state_d = ST_FILL;
            end
         end
         ST_WRBK: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ack) state_d = ST_FILL;
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               fill_en = 1'b1;
               state_d = ST_LOOK;
            end
         end
         default: state_d = ST_LOOK;
      endcase
   end

   // R8: a finished write-back is followed directly by a fill request
   p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   // R10: the processor is never released while memory is busy
   p_no_ready_in_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache #(
   parameter int ADDR_W = 24,
   parameter int IDX_W  = 8,
   parameter int OFF_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_valid,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [7:0]              cpu_wdata,
   output logic                    cpu_ready,
   output logic [7:0]              cpu_rdata,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [(8<<OFF_W)-1:0]   mem_wdata,
   input  logic [(8<<OFF_W)-1:0]   mem_rdata,
   input  logic                    mem_ack
);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = 8 << OFF_W;

   if (TAG_W < 1 || IDX_W < 1 || OFF_W < 1) begin : g_bad_split
      $error("cwb_cache: address split leaves an empty field");
   end

   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [OFF_W-1:0]  req_off;
   logic [TAG_W-1:0]  st_tag;
   logic              st_valid, st_dirty, tag_eq;
   logic              byte_we, mark_en, fill_en;
   logic [LINE_W-1:0] line_rd;

   assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_idx = cpu_addr[OFF_W +: IDX_W];
   assign req_off = cpu_addr[OFF_W-1:0];
   assign tag_eq  = (st_tag == req_tag);

   cwb_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(req_idx),
      .fill_en(fill_en), .fill_tag(req_tag), .mark_en(mark_en),
      .rd_tag(st_tag), .rd_valid(st_valid), .rd_dirty(st_dirty)
   );

   cwb_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
      .clk(clk), .idx(req_idx), .off(req_off),
      .line_we(fill_en), .line_wdata(mem_rdata),
      .byte_we(byte_we), .byte_wdata(cpu_wdata),
      .line_rdata(line_rd)
   );

   cwb_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
      .line_valid(st_valid), .tag_eq(tag_eq), .line_dirty(st_dirty),
      .mem_ack(mem_ack), .cpu_ready(cpu_ready), .byte_we(byte_we),
      .mark_en(mark_en), .fill_en(fill_en), .mem_req(mem_req), .mem_we(mem_we)
   );

   assign cpu_rdata = line_rd[{req_off, 3'b000} +: 8];
   assign mem_wdata = line_rd;
   assign mem_addr  = mem_we ? {st_tag, req_idx, {OFF_W{1'b0}}}
                             : {req_tag, req_idx, {OFF_W{1'b0}}};

   // R10: an open memory request holds until acknowledged
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R6: memory transactions are always line aligned
   p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/sim_cwb_cache.sv
module sim_cwb_cache;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_valid = 1'b0, cpu_we = 1'b0;
   logic [23:0]  cpu_addr = '0;
   logic [7:0]   cpu_wdata = '0;
   logic         cpu_ready;
   logic [7:0]   cpu_rdata;
   logic         mem_req, mem_we;
   logic [23:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic [127:0] mem_rdata = '0;
   logic         mem_ack = 1'b0;

   always #4 clk = ~clk;

   cwb_cache u0 (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   int checks = 0, errors = 0;
   int last_fill = 0, last_wb = 0;

   logic [7:0]  gm [logic [23:0]];
   logic [7:0]  bk [logic [23:0]];
   bit          rv [256];
   bit          rdy [256];
   logic [11:0] rt [256];

   function automatic logic [7:0] dflt(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
   endfunction
   function automatic logic [7:0] gbyte(input logic [23:0] a);
      return gm.exists(a) ? gm[a] : dflt(a);
   endfunction
   function automatic logic [7:0] bbyte(input logic [23:0] a);
      return bk.exists(a) ? bk[a] : dflt(a);
   endfunction

   task automatic chk(input bit ok, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [23:0] a, input logic [7:0] d);
      logic [7:0]  ix = a[11:4];
      logic [11:0] tg = a[23:12];
      bit exp_hit = rv[ix] && (rt[ix] == tg);
      bit exp_wb  = rv[ix] && (rt[ix] != tg) && rdy[ix];
      int cyc = 0, nfill = 0, nwb = 0, wl = 0;
      bit intx = 0;
      logic [127:0] ln;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      forever begin
         #1;
         if (cpu_ready) begin
            if (!we) chk(cpu_rdata == gbyte(a), "R4 read byte", cpu_rdata, gbyte(a));
            break;
         end
         if (mem_req) begin
            if (!intx) begin intx = 1; wl = $urandom_range(0, 3); end
            if (wl == 0) begin
               intx = 0;
               mem_ack = 1'b1;
               if (mem_we) begin
                  nwb++;
                  chk(exp_wb && nfill == 0, "R8 write-back expected before fill", nwb, exp_wb);
                  chk(mem_addr == {rt[ix], ix, 4'h0}, "R8 write-back address",
                      mem_addr, {rt[ix], ix, 4'h0});
                  for (int k = 0; k < 16; k++)
                     ln[8*k +: 8] = gbyte({rt[ix], ix, k[3:0]});
                  chk(mem_wdata == ln, "R11 write-back line", mem_wdata, ln);
                  for (int k = 0; k < 16; k++)
                     bk[{rt[ix], ix, k[3:0]}] = mem_wdata[8*k +: 8];
               end else begin
                  nfill++;
                  chk(nwb == (exp_wb ? 1 : 0), "R7 R8 write-back count before fill",
                      nwb, exp_wb);
                  chk(mem_addr == {a[23:4], 4'h0}, "R6 fill address",
                      mem_addr, {a[23:4], 4'h0});
                  for (int k = 0; k < 16; k++)
                     mem_rdata[8*k +: 8] = bbyte({a[23:4], k[3:0]});
                  rv[ix] = 1; rdy[ix] = 0; rt[ix] = tg;
               end
            end else wl--;
         end
         @(negedge clk);
         mem_ack = 1'b0;
         cyc++;
         if (cyc > 60) begin
            chk(0, "R10 access never completed", cyc, 60);
            break;
         end
      end
      if (exp_hit)
         chk(cyc == 0 && nfill == 0 && nwb == 0, "R3 hit in presenting cycle", cyc, 0);
      else begin
         chk(nfill == 1, "R6 R7 one fill per miss", nfill, 1);
         chk(nwb == (exp_wb ? 1 : 0), "R8 write-back count", nwb, exp_wb);
      end
      if (we) begin gm[a] = d; rdy[ix] = 1; end
      last_fill = nfill; last_wb = nwb;
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!cpu_ready && !mem_req, "R1 idle after reset", {cpu_ready, mem_req}, 0);

      access(0, 24'hAB7129, 0);
      chk(last_fill == 1 && last_wb == 0, "R1 first access fills only", last_wb, 0);
      access(0, 24'hAB7123, 0);
      chk(last_fill == 0, "R3 resident read", last_fill, 0);
      access(1, 24'hAB712C, 8'h3C);
      access(1, 24'hAB712C, 8'h4D);
      access(0, 24'hAB712C, 0);
      access(0, 24'hCD4120, 0);
      chk(last_wb == 1, "R5 modified line copied back", last_wb, 1);
      access(0, 24'hCD412F, 0);
      access(0, 24'hAB7121, 0);
      chk(last_wb == 0 && last_fill == 1, "R9 R7 clean line replaced", last_wb, 0);
      access(1, 24'h000120, 8'h11);
      access(1, 24'h000130, 8'h22);
      access(0, 24'h000120, 0);
      chk(last_fill == 0, "R2 distinct index kept", last_fill, 0);
      access(0, 24'h000130, 0);
      chk(last_fill == 0, "R2 second index kept", last_fill, 0);
      access(1, 24'h555F00, 8'h99);
      access(0, 24'h555F00, 0);
      chk(last_fill == 0, "R9 pending write done after fill", last_fill, 0);
      access(0, 24'h111F03, 0);
      chk(last_wb == 1, "R9 R5 fill then write marks modified", last_wb, 1);

      for (int n = 0; n < 3000; n++) begin
         logic [23:0] a;
         a = {10'h0, 2'($urandom_range(0, 3)), 4'h0, 4'($urandom_range(0, 3)),
              4'($urandom)};
         access(1'($urandom), a, 8'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule